// File: doc/BRIEF.md
# Dual-Channel Audio Sample FIFO Controller

This block is a byte-wide playback engine for two audio channels. It has two 1024-byte sample queues, channel A for the left side and channel B for the right side. A host bus pushes 8-bit samples into the queues by writing to two address windows. The same bus reaches a small register bank that holds the play mode, a configuration byte, a flush command and a status byte.

A single-cycle sample tick, honoured only while the play mode is "FIFO playback", takes the byte at the head of each queue. It turns each byte into a signed output word and registers it onto the left and right outputs. The tick then retires that byte if the queue holds any.

After each tick the block records sticky status flags: a queue has dropped below its low mark, or a queue has drained. Any new flag raises a level interrupt. Reading the status byte returns the flags, clears them and drops the interrupt. In mono configuration the right queue is left alone and the left sample feeds both outputs.

Top module: `audio_fifo_engine`

## Requirements
- R1: A host write to address 0x000–0x3FF stores the data byte at queue A's write position, and a write to 0x400–0x7FF stores it at queue B's write position. The position advances and the fill count rises by one. A write in the same cycle as a pop of that queue leaves the count unchanged.
- R2: Register reads are combinational on `bus_rdata`. 0x800 returns the constant identifier 0x5A, and writes there are ignored. 0x801 returns the play mode, of which only data bits 1:0 are stored. 0x802 returns the whole stored configuration byte. 0x803 returns 0. 0x804 returns the status byte with bits 7:4 at zero. Every other address reads 0.
- R3: Play modes are 0 idle, 1 FIFO playback and 2 wavetable. A tick while the mode is 1 loads each output with (head byte with bit 7 inverted, taken as signed 8-bit) × 64 as a 16-bit two's-complement word. The read position then advances and the count falls, but only if the count is nonzero, so an empty queue repeats the byte at its read position. A tick in any other mode changes nothing.
- R4: Read and write positions wrap from 1023 to 0.
- R5: Writing 0x801 with a mode value that differs from the stored one sets both read positions to 0. Write positions and counts are kept. Writing the same value has no effect on the queues.
- R6: A write to 0x803 with data bit 7 set zeroes both read positions, both write positions and both counts, and sets status bits 1 and 3. It does not change the interrupt. A write to 0x803 with bit 7 clear does nothing.
- R7: After a tick in mode 1, status bit 0 is set if A's new count is below 0x1FF, and bit 1 is set if that count is 0. Bits 2 and 3 are the same flags for B. Any flag set by a tick drives `irq` high from the next cycle.
- R8: A status read returns the current flags, then clears every status bit and lowers `irq`. A flag set by a tick in the same cycle as the read survives.
- R9: With configuration bit 1 set (mono), a tick neither pops queue B nor sets status bits 2 and 3, and `right_out` equals `left_out`.
- R10: A write to a queue whose count is 1024 is dropped, and the queue's contents and count stay as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe; needed only for the clearing status read |
| bus_addr | input | 12 | Host byte address |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, combinational from `bus_addr` |
| sample_tick | input | 1 | One-cycle sample-rate enable |
| left_out | output | 16 | Left output word, signed |
| right_out | output | 16 | Right output word, signed |
| irq | output | 1 | Level interrupt, active high |

## Verification
The assertions take for granted that reset is held high at the start, that `sample_tick` is a one-cycle enable, and that the queue depth is a power of two, so that position wrap comes from the register width. The stimulus fills every storage byte once before the first tick. This means an empty-queue repeat or a read position sent home by a mode change always addresses a byte with a known value. Bus accesses use one address per cycle. The cases the requirements single out are driven on purpose: a status read and a tick in the same cycle, a push and a tick in the same cycle, and a flush during playback.

// File: rtl/afe_pkg.sv
package afe_pkg;

    localparam int FIFO_DEPTH = 1024;
    localparam int NUM_CH     = 2;
    localparam int BUS_AW     = 12;
    localparam int SAMPLE_W   = 8;
    localparam int OUT_W      = 16;
    localparam int GAIN_SHIFT = 6;
    localparam int LOW_MARK   = 511;

    localparam logic [BUS_AW-1:0] OFS_ID   = 12'h800;
    localparam logic [BUS_AW-1:0] OFS_MODE = 12'h801;
    localparam logic [BUS_AW-1:0] OFS_CFG  = 12'h802;
    localparam logic [BUS_AW-1:0] OFS_CMD  = 12'h803;
    localparam logic [BUS_AW-1:0] OFS_STS  = 12'h804;

    localparam int CFG_MONO_BIT  = 1;
    localparam int CMD_FLUSH_BIT = 7;

    typedef enum logic [1:0] {
        PM_IDLE  = 2'd0,
        PM_FIFO  = 2'd1,
        PM_WAVE  = 2'd2,
        PM_SPARE = 2'd3
    } play_mode_e;

    // per-channel status pair; element 0 = channel A occupies bits 1:0
    typedef struct packed {
        logic drained;
        logic below_mark;
    } ch_flags_t;

    typedef ch_flags_t [NUM_CH-1:0] status_t;

    localparam status_t STS_ALL_DRAINED = 4'b1010;

    function automatic logic signed [OUT_W-1:0] sample_to_word(input logic [SAMPLE_W-1:0] b);
        logic signed [SAMPLE_W-1:0] s;
        logic signed [OUT_W-1:0]    w;
        s = {~b[SAMPLE_W-1], b[SAMPLE_W-2:0]};
        w = {{(OUT_W-SAMPLE_W){s[SAMPLE_W-1]}}, s};
        return w <<< GAIN_SHIFT;
    endfunction

endpackage

// File: rtl/afe_sample_fifo.sv
module afe_sample_fifo #(
    parameter int DEPTH = afe_pkg::FIFO_DEPTH,
    parameter int PW    = $clog2(DEPTH),
    parameter int CW    = PW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [7:0]    push_data,
    input  logic          pop_en,
    input  logic          clr_all,
    input  logic          rd_home,
    output logic [7:0]    head_byte,
    output logic [CW-1:0] count_next
);

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_ptr;
    logic [CW-1:0] count;
    logic          full;
    logic          accept;
    logic          do_pop;

    assign full       = (count == CW'(DEPTH));
    assign accept     = push && !clr_all && !full;
    assign do_pop     = pop_en && !clr_all && (count != '0);
    assign head_byte  = mem[rd_ptr];
    assign count_next = clr_all ? '0 : (count + CW'(accept) - CW'(do_pop));

    always_ff @(posedge clk) begin
        if (accept) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            count <= count_next;
            if (clr_all) begin
                wr_ptr <= '0;
            end else if (accept) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (clr_all || rd_home) begin
                rd_ptr <= '0;
            end else if (do_pop) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
        end
    end

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    assert_full_drop_R10: assert property (@(posedge clk) disable iff (rst)
        (push && full && !clr_all && !pop_en) |=> (count == CW'(DEPTH)));

    assert_empty_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (pop_en && count == '0 && !clr_all && !rd_home) |=> (rd_ptr == $past(rd_ptr)));

    assert_flush_R6: assert property (@(posedge clk) disable iff (rst)
        clr_all |=> (count == '0 && rd_ptr == '0 && wr_ptr == '0));

endmodule

// File: rtl/afe_regs.sv
module afe_regs
    import afe_pkg::*;
#(
    parameter int          CW       = 11,
    parameter logic [7:0]  ID_VALUE = 8'h5A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              sample_tick,
    input  logic [CW-1:0]     a_cnt_next,
    input  logic [CW-1:0]     b_cnt_next,
    output logic              push_a,
    output logic              push_b,
    output logic              pop_a,
    output logic              pop_b,
    output logic              clr_all,
    output logic              rd_home,
    output logic              live,
    output logic              mono,
    output logic [7:0]        bus_rdata,
    output logic              irq
);

    play_mode_e mode_q;
    logic [7:0] cfg_q;
    status_t    sts_q;
    status_t    tick_flags;
    status_t    sts_next;
    logic       irq_q;
    logic       sts_rd;
    logic       mode_wr;
    play_mode_e mode_in;

    assign push_a  = bus_wr && (bus_addr[BUS_AW-1:BUS_AW-2] == 2'b00);
    assign push_b  = bus_wr && (bus_addr[BUS_AW-1:BUS_AW-2] == 2'b01);
    assign clr_all = bus_wr && (bus_addr == OFS_CMD) && bus_wdata[CMD_FLUSH_BIT];
    assign mode_wr = bus_wr && (bus_addr == OFS_MODE);
    assign mode_in = play_mode_e'(bus_wdata[1:0]);
    assign rd_home = mode_wr && (mode_in != mode_q);
    assign sts_rd  = bus_rd && (bus_addr == OFS_STS);

    assign mono  = cfg_q[CFG_MONO_BIT];
    assign live  = sample_tick && (mode_q == PM_FIFO);
    assign pop_a = live;
    assign pop_b = live && !mono;
    assign irq   = irq_q;

    always_comb begin
        tick_flags = '0;
        if (pop_a) begin
            tick_flags[0].below_mark = (a_cnt_next < CW'(LOW_MARK));
            tick_flags[0].drained    = (a_cnt_next == '0);
        end
        if (pop_b) begin
            tick_flags[1].below_mark = (b_cnt_next < CW'(LOW_MARK));
            tick_flags[1].drained    = (b_cnt_next == '0);
        end
        sts_next = (sts_rd ? status_t'('0) : sts_q) | tick_flags
                 | (clr_all ? STS_ALL_DRAINED : status_t'('0));
    end

    always_comb begin
        unique case (bus_addr)
            OFS_ID:   bus_rdata = ID_VALUE;
            OFS_MODE: bus_rdata = {6'b0, mode_q};
            OFS_CFG:  bus_rdata = cfg_q;
            OFS_STS:  bus_rdata = {4'b0, sts_q};
            default:  bus_rdata = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= PM_IDLE;
            cfg_q  <= '0;
            sts_q  <= '0;
            irq_q  <= 1'b0;
        end else begin
            sts_q <= sts_next;
            irq_q <= (sts_rd ? 1'b0 : irq_q) | (|tick_flags);
            if (mode_wr) begin
                mode_q <= mode_in;
            end
            if (bus_wr && bus_addr == OFS_CFG) begin
                cfg_q <= bus_wdata;
            end
        end
    end

    assert_status_read_R8: assert property (@(posedge clk) disable iff (rst)
        (sts_rd && tick_flags == '0 && !clr_all) |=> (sts_q == '0 && !irq_q));

    assert_irq_on_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (tick_flags != '0) |=> irq_q);

    assert_mono_b_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (mono && !clr_all && sts_q[1] == 2'b00 && !sts_rd) |=> (sts_q[1] == 2'b00));

    assert_mode_width_R2: assert property (@(posedge clk) disable iff (rst)
        mode_wr |=> (mode_q == play_mode_e'($past(bus_wdata[1:0]))));

endmodule

// File: rtl/afe_out_stage.sv
module afe_out_stage
    import afe_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    live,
    input  logic                    mono,
    input  logic [SAMPLE_W-1:0]     head_a,
    input  logic [SAMPLE_W-1:0]     head_b,
    output logic signed [OUT_W-1:0] left_word,
    output logic signed [OUT_W-1:0] right_word
);

    logic signed [OUT_W-1:0] left_d;
    logic signed [OUT_W-1:0] right_d;

    assign left_d  = sample_to_word(head_a);
    assign right_d = mono ? left_d : sample_to_word(head_b);

    always_ff @(posedge clk) begin
        if (rst) begin
            left_word  <= '0;
            right_word <= '0;
        end else if (live) begin
            left_word  <= left_d;
            right_word <= right_d;
        end
    end

    assert_mono_copy_R9: assert property (@(posedge clk) disable iff (rst)
        (live && mono) |=> (right_word == left_word));

    assert_hold_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !live |=> ($stable(left_word) && $stable(right_word)));

endmodule

// File: rtl/audio_fifo_engine.sv
module audio_fifo_engine
    import afe_pkg::*;
#(
    parameter int         DEPTH    = FIFO_DEPTH,
    parameter logic [7:0] ID_VALUE = 8'h5A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              sample_tick,
    output logic [OUT_W-1:0]  left_out,
    output logic [OUT_W-1:0]  right_out,
    output logic              irq
);

    localparam int CW = $clog2(DEPTH) + 1;

    logic [NUM_CH-1:0] push_v;
    logic [NUM_CH-1:0] pop_v;
    logic [7:0]        head   [NUM_CH];
    logic [CW-1:0]     cnt_nx [NUM_CH];
    logic              clr_all;
    logic              rd_home;
    logic              live;
    logic              mono;
    logic signed [OUT_W-1:0] left_w;
    logic signed [OUT_W-1:0] right_w;

    afe_regs #(
        .CW       (CW),
        .ID_VALUE (ID_VALUE)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .sample_tick (sample_tick),
        .a_cnt_next  (cnt_nx[0]),
        .b_cnt_next  (cnt_nx[1]),
        .push_a      (push_v[0]),
        .push_b      (push_v[1]),
        .pop_a       (pop_v[0]),
        .pop_b       (pop_v[1]),
        .clr_all     (clr_all),
        .rd_home     (rd_home),
        .live        (live),
        .mono        (mono),
        .bus_rdata   (bus_rdata),
        .irq         (irq)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        afe_sample_fifo #(
            .DEPTH (DEPTH)
        ) u_fifo (
            .clk        (clk),
            .rst        (rst),
            .push       (push_v[ch]),
            .push_data  (bus_wdata),
            .pop_en     (pop_v[ch]),
            .clr_all    (clr_all),
            .rd_home    (rd_home),
            .head_byte  (head[ch]),
            .count_next (cnt_nx[ch])
        );
    end

    afe_out_stage u_out (
        .clk        (clk),
        .rst        (rst),
        .live       (live),
        .mono       (mono),
        .head_a     (head[0]),
        .head_b     (head[1]),
        .left_word  (left_w),
        .right_word (right_w)
    );

    assign left_out  = left_w;
    assign right_out = right_w;

endmodule

// File: tb/test_audio_fifo_engine.sv
module test_audio_fifo_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        sample_tick = 1'b0;
    logic [7:0]  bus_rdata;
    logic [15:0] left_out;
    logic [15:0] right_out;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference state
    int mm [2][1024];
    int rp [2];
    int wp [2];
    int cnt[2];
    int m_mode, m_cfg, m_sts, m_irq, m_lo, m_ro;

    always #5 clk = ~clk;

    audio_fifo_engine i_audio_fifo_engine (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sample_tick(sample_tick), .left_out(left_out), .right_out(right_out),
        .irq(irq)
    );

    function automatic int to_word(input int b);
        int s;
        s = b ^ 8'h80;
        if (s >= 128) s = s - 256;
        return s * 64;
    endfunction

    function automatic int exp_rdata(input int a);
        case (a)
            12'h800: return 8'h5A;
            12'h801: return m_mode;
            12'h802: return m_cfg;
            12'h804: return m_sts;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        int a, d, flags;
        bit clr, home, live, mono, rd_s;
        bit push [2];
        bit popn [2];
        if (rst) begin
            for (int c = 0; c < 2; c++) begin rp[c] = 0; wp[c] = 0; cnt[c] = 0; end
            m_mode = 0; m_cfg = 0; m_sts = 0; m_irq = 0; m_lo = 0; m_ro = 0;
            return;
        end
        a    = int'(bus_addr);
        d    = int'(bus_wdata);
        clr  = bus_wr && a == 12'h803 && d[7];
        home = bus_wr && a == 12'h801 && (d & 3) != m_mode;
        rd_s = bus_rd && a == 12'h804;
        mono = (m_cfg & 2) != 0;
        live = sample_tick && m_mode == 1;
        push[0] = bus_wr && a < 12'h400;
        push[1] = bus_wr && a >= 12'h400 && a < 12'h800;
        popn[0] = live;
        popn[1] = live && !mono;
        if (live) begin
            m_lo = to_word(mm[0][rp[0]]);
            m_ro = mono ? m_lo : to_word(mm[1][rp[1]]);
        end
        flags = 0;
        for (int c = 0; c < 2; c++) begin
            bit acc, dp;
            acc = push[c] && !clr && cnt[c] < 1024;
            dp  = popn[c] && !clr && cnt[c] > 0;
            if (acc) begin mm[c][wp[c]] = d; wp[c] = (wp[c] + 1) % 1024; end
            if (clr) begin cnt[c] = 0; wp[c] = 0; end
            else cnt[c] = cnt[c] + int'(acc) - int'(dp);
            if (clr || home) rp[c] = 0;
            else if (dp) rp[c] = (rp[c] + 1) % 1024;
            if (popn[c]) begin
                if (cnt[c] < 12'h1FF) flags |= (1 << (2 * c));
                if (cnt[c] == 0)      flags |= (2 << (2 * c));
            end
        end
        m_sts = (rd_s ? 0 : m_sts) | flags | (clr ? 8'h0A : 0);
        m_irq = (rd_s ? 0 : m_irq) | int'(flags != 0);
        if (bus_wr && a == 12'h801) m_mode = d & 3;
        if (bus_wr && a == 12'h802) m_cfg = d;
    endtask

    task automatic step(input bit w, input bit r, input int a, input int d,
                        input bit t, input string tag);
        bus_wr = w; bus_rd = r; bus_addr = 12'(a); bus_wdata = 8'(d); sample_tick = t;
        #1;
        if (r) chk({tag, " rdata"}, int'(bus_rdata), exp_rdata(a));
        @(posedge clk);
        model_edge();
        #1;
        chk({tag, " left"},  int'(left_out),  m_lo & 16'hFFFF);
        chk({tag, " right"}, int'(right_out), m_ro & 16'hFFFF);
        chk({tag, " irq"},   int'(irq),       m_irq);
        @(negedge clk);
    endtask

    task automatic wr(input int a, input int d, input string tag);
        step(1, 0, a, d, 0, tag);
    endtask

    task automatic rd(input int a, input string tag);
        step(0, 1, a, 0, 0, tag);
    endtask

    task automatic tk(input string tag);
        step(0, 0, 0, 0, 1, tag);
    endtask

    initial begin
        @(negedge clk);
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, "reset");
        rst = 1'b0;
        // R2 reset state and register map
        rd(12'h800, "R2"); rd(12'h801, "R2"); rd(12'h802, "R2");
        rd(12'h803, "R2"); rd(12'h804, "R2"); rd(12'h123, "R2");
        wr(12'h800, 8'h00, "R2"); rd(12'h800, "R2");
        // R1 fill both queues, R10 overflow dropped
        for (int i = 0; i < 1024; i++) wr(i, (i * 37 + 11) & 255, "R1");
        wr(12'h3FF, 8'hEE, "R10");
        for (int i = 0; i < 1024; i++) wr(12'h400 + i, (i * 53 + 5) & 255, "R1");
        wr(12'h7FF, 8'hEE, "R10");
        wr(12'h802, 8'h00, "R2");
        wr(12'h801, 8'hFD, "R2");  // stores only bits 1:0 -> mode 1
        rd(12'h801, "R2");
        // R3 R7 R8 drain beyond empty, reads colliding with ticks
        for (int i = 0; i < 1030; i++) begin
            step(0, (i % 97) == 0, 12'h804, 0, 1, "R3");
            if (i % 5 == 0) step(0, 0, 0, 0, 0, "R7");
        end
        rd(12'h804, "R8"); rd(12'h804, "R8");
        // R4 wrap of write and read positions
        for (int i = 0; i < 20; i++) begin
            wr(100 + i, (i * 11 + 3) & 255, "R4");
            wr(12'h500 + i, (i * 29 + 7) & 255, "R4");
        end
        for (int i = 0; i < 25; i++) tk("R4");
        rd(12'h804, "R7");
        // R5 mode changes
        for (int i = 0; i < 8; i++) wr(i, (i * 71 + 1) & 255, "R5");
        wr(12'h801, 1, "R5");
        tk("R5"); tk("R5");
        wr(12'h801, 0, "R5");
        tk("R3"); tk("R3"); tk("R3");
        wr(12'h801, 2, "R3");
        tk("R3");
        wr(12'h801, 1, "R5");
        for (int i = 0; i < 10; i++) tk("R5");
        // R6 flush
        rd(12'h804, "R6");
        for (int i = 0; i < 6; i++) wr(200 + i, i * 9, "R6");
        wr(12'h803, 8'h7F, "R6");
        tk("R6");
        wr(12'h803, 8'h80, "R6");
        rd(12'h804, "R6");
        tk("R6"); tk("R6");
        rd(12'h804, "R6");
        // R9 mono
        wr(12'h802, 8'h02, "R9");
        for (int i = 0; i < 6; i++) begin
            wr(i, (i * 19 + 200) & 255, "R9");
            wr(12'h400 + i, (i * 23 + 1) & 255, "R9");
        end
        rd(12'h804, "R9");
        for (int i = 0; i < 10; i++) tk("R9");
        rd(12'h804, "R9");
        wr(12'h802, 8'h00, "R9");
        for (int i = 0; i < 8; i++) tk("R9");
        rd(12'h804, "R9");
        // R1 push and tick in the same cycle
        for (int i = 0; i < 12; i++) begin
            step(1, 0, 300 + i, (i * 41 + 9) & 255, 1, "R1");
            step(1, 0, 12'h600 + i, (i * 43 + 2) & 255, 1, "R1");
        end
        for (int i = 0; i < 16; i++) tk("R1");
        rd(12'h804, "R8");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule